// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-page to physical-page mappings and translates requester addresses against all of them at once. A requester presents a virtual address with an access type. If a stored mapping matches, the physical address is the stored physical page number followed by the untouched page offset, and it comes back in the same cycle. If nothing matches, the requester is stalled and the block asks an external table walker for the mapping. The requester must hold its request stable while stalled. A missing mapping here is only a translation miss. A page fault is reported only when the walker itself answers that no valid mapping exists.

Each slot holds an in-use flag, the virtual page number, the physical page number, three permission bits and a modified flag. Successful walk results are stored. Unused slots are filled first, and once every slot is in use a round-robin pointer picks the slot to replace. A store to a page whose modified flag is clear raises a one-cycle notice carrying the page number, so the table held in memory can be brought up to date. A flush input empties the whole array in one cycle.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no response, walk request, stall or modified notice is asserted, and every slot is unused.
- R2: A request whose page matches an in-use slot, with the access permitted, gives rsp_valid in the same cycle, with rsp_pa equal to the stored physical page number joined to the request's low 12 offset bits. The stall stays low and no walk starts.
- R3: A request that matches no slot raises req_stall in the same cycle, with no response. walk_req rises on the next cycle with walk_vpn equal to the request's page number. Both hold until walk_done, and only one walk is ever outstanding.
- R4: When walk_done arrives with walk_ok high, the response is given in that cycle with rsp_pa equal to {walk_ppn, offset}, and the stall drops. The mapping is stored, so the next request to that page hits.
- R5: When walk_done arrives with walk_ok low, the block responds with rsp_fault high and rsp_pa zero, and stores nothing. A repeat of the same page misses again.
- R6: Unused slots are filled before any in-use slot is replaced. As many distinct pages as there are slots can therefore be held at once, and all of them hit.
- R7: When every slot is in use, an insert replaces the slot under a round-robin pointer. The pointer starts at slot 0 and advances by one on each replacement, so the oldest-filled page of a fresh fill is the first to be evicted.
- R8: Permission bits: bit 0 allows load, bit 1 allows store, bit 2 allows fetch. The access codes are 00 load, 01 store and 10 fetch, and code 11 is never allowed. A disallowed access gives rsp_valid with rsp_prot_fault high and rsp_pa zero, and it neither raises the modified notice nor changes the modified flag.
- R9: A permitted store hit on a slot whose modified flag is clear raises dirty_note in that cycle, with dirty_vpn equal to the page, and sets the flag. A later store to that page raises no notice.
- R10: A permitted store completed through a walk with walk_dirty low raises dirty_note in the completion cycle, and the page is stored already modified.
- R11: A flush makes every slot unused from the next cycle on. A walk that completes in the same cycle as a flush is still answered, but it is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties every slot |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address, held while stalled |
| req_acc | input | 2 | Access type: 00 load, 01 store, 10 fetch |
| req_stall | output | 1 | Request not yet answered |
| rsp_valid | output | 1 | Response this cycle |
| rsp_pa | output | 32 | Physical address, zero on any fault |
| rsp_fault | output | 1 | Walker found no valid mapping |
| rsp_prot_fault | output | 1 | Access type not permitted by the page |
| dirty_note | output | 1 | First store to an unmodified page |
| dirty_vpn | output | 20 | Page number for the notice |
| walk_req | output | 1 | Walk requested, held until walk_done |
| walk_vpn | output | 20 | Page number to walk |
| walk_done | input | 1 | Walker answer present |
| walk_ok | input | 1 | Walker found a valid mapping |
| walk_ppn | input | 20 | Physical page number from the walker |
| walk_perm | input | 3 | Permission bits from the walker |
| walk_dirty | input | 1 | Page already modified in memory |

## Verification
A corrupted in-use flag or page tag shows up at the ports on the very next request to that page. A dropped slot shows as a stall and a walk_req one cycle later, and a stale slot shows as a wrong rsp_pa in the same cycle. A round-robin pointer that has drifted does not show at once. It shows only when a page that should have been kept starts to miss, one replacement after the drift, so the bench fills the array exactly and then checks which pages survive each eviction. A lost modified flag shows as a repeated dirty_note on the second store.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic {
    MST_IDLE = 1'b0,
    MST_WALK = 1'b1
  } mst_e;

  localparam int PERM_W = 3;
  localparam int PB_LOAD  = 0;
  localparam int PB_STORE = 1;
  localparam int PB_FETCH = 2;

  function automatic logic access_allowed(input logic [PERM_W-1:0] perm,
                                          input logic [1:0] acc);
    logic ok;
    case (acc)
      ACC_LOAD:  ok = perm[PB_LOAD];
      ACC_STORE: ok = perm[PB_STORE];
      ACC_FETCH: ok = perm[PB_FETCH];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [VPN_W-1:0]     look_vpn,
  input  logic                 ins_en,
  input  logic [IDX_W-1:0]     ins_idx,
  input  logic [VPN_W-1:0]     ins_vpn,
  input  logic [PPN_W-1:0]     ins_ppn,
  input  logic [PERM_W-1:0]    ins_perm,
  input  logic                 ins_dirty,
  input  logic                 mark_en,
  input  logic [IDX_W-1:0]     mark_idx,
  output logic                 hit,
  output logic [IDX_W-1:0]     hit_idx,
  output logic [PPN_W-1:0]     hit_ppn,
  output logic [PERM_W-1:0]    hit_perm,
  output logic                 hit_dirty,
  output logic [ENTRIES-1:0]   used
);

  logic [ENTRIES-1:0] used_q, used_d;
  logic [ENTRIES-1:0] dirty_q, dirty_d;
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_slot
      assign wr_sel[g] = ins_en && !flush && (ins_idx == IDX_W'(g));
      assign match[g]  = used_q[g] && (vpn_q[g] == look_vpn);

      always_comb begin
        if (flush)       used_d[g] = 1'b0;
        else if (wr_sel[g]) used_d[g] = 1'b1;
        else             used_d[g] = used_q[g];

        if (wr_sel[g])   dirty_d[g] = ins_dirty;
        else if (mark_en && (mark_idx == IDX_W'(g))) dirty_d[g] = 1'b1;
        else             dirty_d[g] = dirty_q[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q  <= '0;
      dirty_q <= '0;
    end else begin
      used_q  <= used_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_sel[i]) begin
        vpn_q[i]  <= ins_vpn;
        ppn_q[i]  <= ins_ppn;
        perm_q[i] <= ins_perm;
      end
    end
  end

  always_comb begin
    hit_idx   = '0;
    hit_ppn   = '0;
    hit_perm  = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_idx   = hit_idx | IDX_W'(i);
        hit_ppn   = hit_ppn | ppn_q[i];
        hit_perm  = hit_perm | perm_q[i];
        hit_dirty = hit_dirty | dirty_q[i];
      end
    end
  end

  assign hit  = |match;
  assign used = used_q;

  // R2: a page is never held twice, so the OR-mux readout is exact
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R11: flush empties the array on the following cycle
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (used_q == '0));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ENTRIES-1:0]  used,
  input  logic                pick_en,
  output logic [IDX_W-1:0]    victim_idx,
  output logic                full
);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] free_idx;
  logic             ptr_adv;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!used[i]) free_idx = IDX_W'(i);
    end
  end

  assign full       = &used;
  assign victim_idx = full ? ptr_q : free_idx;
  assign ptr_adv    = pick_en && full;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_adv) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
      else                              ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R6: while a slot is free, an insert never lands on an in-use slot
  p_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_en && !full) |-> !used[victim_idx]);

  // R7: the pointer moves only on a replacement
  p_ptr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pick_en && full) |=> $stable(ptr_q));

endmodule

// File: rtl/xlat_miss_ctl.sv
module xlat_miss_ctl
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              hit,
  input  logic [VPN_W-1:0]  look_vpn,
  input  logic              walk_done,
  output logic              in_walk,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn
);

  mst_e             st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic             start;

  assign start = (st_q == MST_IDLE) && req_valid && !hit;

  always_comb begin
    st_d = st_q;
    case (st_q)
      MST_IDLE: if (start)     st_d = MST_WALK;
      MST_WALK: if (walk_done) st_d = MST_IDLE;
      default:                 st_d = MST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (start) vpn_q <= look_vpn;
  end

  assign in_walk  = (st_q == MST_WALK);
  assign walk_req = in_walk;
  assign walk_vpn = vpn_q;

  // R3: an outstanding walk holds its request and page number until answered
  p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_done) |=> (walk_req && $stable(walk_vpn)));

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_va,
  input  logic [1:0]           req_acc,
  output logic                 req_stall,
  output logic                 rsp_valid,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 rsp_fault,
  output logic                 rsp_prot_fault,
  output logic                 dirty_note,
  output logic [VA_W-OFS_W-1:0] dirty_vpn,
  output logic                 walk_req,
  output logic [VA_W-OFS_W-1:0] walk_vpn,
  input  logic                 walk_done,
  input  logic                 walk_ok,
  input  logic [PA_W-OFS_W-1:0] walk_ppn,
  input  logic [2:0]           walk_perm,
  input  logic                 walk_dirty
);

  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   look_vpn;
  logic [OFS_W-1:0]   look_ofs;
  logic               cam_hit;
  logic [IDX_W-1:0]   cam_idx;
  logic [PPN_W-1:0]   cam_ppn;
  logic [PERM_W-1:0]  cam_perm;
  logic               cam_dirty;
  logic [ENTRIES-1:0] cam_used;
  logic [IDX_W-1:0]   victim_idx;
  logic               arr_full;
  logic               in_walk;

  logic look_hit, hit_ok, walk_fin, walk_fin_ok, walk_acc_ok, is_store;
  logic mark_en, ins_en, ins_dirty, note_hit, note_walk;

  assign look_vpn = req_va[VA_W-1:OFS_W];
  assign look_ofs = req_va[OFS_W-1:0];
  assign is_store = (req_acc == ACC_STORE);

  xlat_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .IDX_W   (IDX_W)
  ) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .look_vpn  (look_vpn),
    .ins_en    (ins_en),
    .ins_idx   (victim_idx),
    .ins_vpn   (walk_vpn),
    .ins_ppn   (walk_ppn),
    .ins_perm  (walk_perm),
    .ins_dirty (ins_dirty),
    .mark_en   (mark_en),
    .mark_idx  (cam_idx),
    .hit       (cam_hit),
    .hit_idx   (cam_idx),
    .hit_ppn   (cam_ppn),
    .hit_perm  (cam_perm),
    .hit_dirty (cam_dirty),
    .used      (cam_used)
  );

  xlat_victim #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .used       (cam_used),
    .pick_en    (ins_en),
    .victim_idx (victim_idx),
    .full       (arr_full)
  );

  xlat_miss_ctl #(
    .VPN_W (VPN_W)
  ) u_miss (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hit       (cam_hit),
    .look_vpn  (look_vpn),
    .walk_done (walk_done),
    .in_walk   (in_walk),
    .walk_req  (walk_req),
    .walk_vpn  (walk_vpn)
  );

  // Hit path: only while no walk is outstanding
  assign look_hit    = !in_walk && req_valid && cam_hit;
  assign hit_ok      = access_allowed(cam_perm, req_acc);

  // Walk completion path
  assign walk_fin    = in_walk && walk_done;
  assign walk_fin_ok = walk_fin && walk_ok;
  assign walk_acc_ok = access_allowed(walk_perm, req_acc);

  assign note_hit  = look_hit && hit_ok && is_store && !cam_dirty;
  assign note_walk = walk_fin_ok && walk_acc_ok && is_store && !walk_dirty;

  assign mark_en   = note_hit;
  assign ins_en    = walk_fin_ok;
  assign ins_dirty = walk_dirty || (is_store && walk_acc_ok);

  always_comb begin
    rsp_valid      = look_hit || walk_fin;
    rsp_fault      = walk_fin && !walk_ok;
    rsp_prot_fault = (look_hit && !hit_ok) || (walk_fin_ok && !walk_acc_ok);
    rsp_pa         = '0;
    if (look_hit && hit_ok)            rsp_pa = {cam_ppn, look_ofs};
    else if (walk_fin_ok && walk_acc_ok) rsp_pa = {walk_ppn, look_ofs};
  end

  assign req_stall  = req_valid && !rsp_valid;
  assign dirty_note = note_hit || note_walk;
  assign dirty_vpn  = look_vpn;

  // R2: a hit in idle never starts a walk
  p_hit_no_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!walk_req && req_valid && cam_hit) |=> !walk_req);

  // R5: a failed walk leaves the in-use set untouched
  p_fault_no_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && !flush) |=> $stable(cam_used));

  // R9: the notice only accompanies a permitted store response
  p_note_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_note |-> (rsp_valid && (req_acc == ACC_STORE) && !rsp_prot_fault && !rsp_fault));

  // R8: a protection fault carries no address
  p_prot_no_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot_fault |-> (rsp_pa == '0));

endmodule

// File: tb/xlat_tlb_tb.sv
`timescale 1ns/1ps
module xlat_tlb_tb;

  localparam int N = 16;

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        req_valid;
  logic [31:0] req_va;
  logic [1:0]  req_acc;
  logic        req_stall;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic        rsp_fault;
  logic        rsp_prot_fault;
  logic        dirty_note;
  logic [19:0] dirty_vpn;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        walk_done;
  logic        walk_ok;
  logic [19:0] walk_ppn;
  logic [2:0]  walk_perm;
  logic        walk_dirty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  xlat_tlb #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc),
    .req_stall(req_stall), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_prot_fault(rsp_prot_fault),
    .dirty_note(dirty_note), .dirty_vpn(dirty_vpn),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_done(walk_done),
    .walk_ok(walk_ok), .walk_ppn(walk_ppn), .walk_perm(walk_perm),
    .walk_dirty(walk_dirty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0; walk_done = 1'b0; flush = 1'b0;
  endtask

  task automatic drive(input logic [19:0] vpn, input logic [11:0] ofs, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1'b1; req_va = {vpn, ofs}; req_acc = acc;
    #1;
  endtask

  // request already stalled: wait for walk_req, hold one cycle, then answer
  task automatic answer(input logic ok, input logic [19:0] ppn, input logic [2:0] perm,
                        input logic wd, input logic fl, input string tag);
    @(negedge clk); #1;
    chk({tag, " walk_req raised"}, {31'd0, walk_req}, 32'd1);
    chk({tag, " walk_vpn"}, {12'd0, walk_vpn}, {12'd0, req_va[31:12]});
    @(negedge clk); #1;
    chk({tag, " still stalled"}, {31'd0, req_stall}, 32'd1);
    @(negedge clk);
    walk_done = 1'b1; walk_ok = ok; walk_ppn = ppn; walk_perm = perm;
    walk_dirty = wd; flush = fl;
    #1;
  endtask

  task automatic hit_ok(input logic [19:0] vpn, input logic [11:0] ofs, input logic [1:0] acc,
                        input logic [19:0] ppn, input string tag);
    drive(vpn, ofs, acc);
    chk({tag, " hit valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " hit pa"}, rsp_pa, {ppn, ofs});
    go_idle();
  endtask

  task automatic miss_then(input logic [19:0] vpn, input string tag);
    drive(vpn, 12'h0, 2'b00);
    chk({tag, " miss stalls"}, {30'd0, req_stall, rsp_valid}, 32'd2);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {27'd0, rsp_valid, req_stall, walk_req, dirty_note, rsp_fault}, 32'd0);
  endtask

  task automatic t_fill_and_hit();
    drive(20'h12345, 12'h678, 2'b00);
    chk("R3 miss stall no rsp", {30'd0, req_stall, rsp_valid}, 32'd2);
    chk("R3 no walk same cycle", {31'd0, walk_req}, 32'd0);
    answer(1'b1, 20'h00ABC, 3'b011, 1'b0, 1'b0, "R3");
    chk("R4 walk rsp valid", {30'd0, rsp_valid, req_stall}, 32'd2);
    chk("R4 walk pa", rsp_pa, 32'h00ABC678);
    go_idle();
    @(negedge clk); #1;
    chk("R3 walk released", {31'd0, walk_req}, 32'd0);
    drive(20'h12345, 12'h0F0, 2'b00);
    chk("R2 hit same cycle", {30'd0, rsp_valid, req_stall}, 32'd2);
    chk("R2 hit pa", rsp_pa, 32'h00ABC0F0);
    go_idle(); #1;
    chk("R2 no walk after hit", {31'd0, walk_req}, 32'd0);
  endtask

  task automatic t_dirty_hit();
    drive(20'h12345, 12'h004, 2'b01);
    chk("R9 first store note", {31'd0, dirty_note}, 32'd1);
    chk("R9 note vpn", {12'd0, dirty_vpn}, 32'h00012345);
    chk("R9 store pa", rsp_pa, 32'h00ABC004);
    go_idle();
    drive(20'h12345, 12'h008, 2'b01);
    chk("R9 second store silent", {30'd0, rsp_valid, dirty_note}, 32'd2);
    go_idle();
  endtask

  task automatic t_prot();
    drive(20'h12345, 12'h010, 2'b10);
    chk("R8 fetch denied", {29'd0, rsp_valid, rsp_prot_fault, rsp_fault}, 32'd6);
    chk("R8 denied pa zero", rsp_pa, 32'd0);
    go_idle();
    drive(20'h12345, 12'h010, 2'b11);
    chk("R8 code 11 denied", {30'd0, rsp_valid, rsp_prot_fault}, 32'd3);
    go_idle();
    miss_then(20'h000AA, "R8");
    answer(1'b1, 20'h00CC1, 3'b101, 1'b0, 1'b0, "R8");
    chk("R8 load walk ok", rsp_pa, 32'h00CC1000);
    go_idle();
    drive(20'h000AA, 12'h020, 2'b01);
    chk("R8 store denied no note", {30'd0, rsp_prot_fault, dirty_note}, 32'd2);
    go_idle();
    drive(20'h000AA, 12'h024, 2'b10);
    chk("R8 fetch allowed", {31'd0, rsp_prot_fault}, 32'd0);
    chk("R8 fetch pa", rsp_pa, 32'h00CC1024);
    go_idle();
  endtask

  task automatic t_walk_store();
    drive(20'h000BB, 12'h100, 2'b01);
    chk("R10 store miss stalls", {31'd0, req_stall}, 32'd1);
    answer(1'b1, 20'h00DD2, 3'b011, 1'b0, 1'b0, "R10");
    chk("R10 note on walk", {31'd0, dirty_note}, 32'd1);
    chk("R10 pa", rsp_pa, 32'h00DD2100);
    go_idle();
    drive(20'h000BB, 12'h104, 2'b01);
    chk("R10 stored modified", {30'd0, rsp_valid, dirty_note}, 32'd2);
    go_idle();
  endtask

  task automatic t_page_fault();
    miss_then(20'h00777, "R5");
    answer(1'b0, 20'h0FFFF, 3'b111, 1'b0, 1'b0, "R5");
    chk("R5 fault rsp", {29'd0, rsp_valid, rsp_fault, req_stall}, 32'd6);
    chk("R5 fault pa zero", rsp_pa, 32'd0);
    go_idle();
    miss_then(20'h00777, "R5 not stored");
    answer(1'b0, 20'h0, 3'b0, 1'b0, 1'b0, "R5");
    go_idle();
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    miss_then(20'h12345, "R11 flushed");
    answer(1'b0, 20'h0, 3'b0, 1'b0, 1'b0, "R11");
    go_idle();
    miss_then(20'h00555, "R11");
    answer(1'b1, 20'h00E00, 3'b001, 1'b0, 1'b1, "R11");
    chk("R11 answered under flush", rsp_pa, 32'h00E00000);
    go_idle();
    miss_then(20'h00555, "R11 insert dropped");
    answer(1'b0, 20'h0, 3'b0, 1'b0, 1'b0, "R11");
    go_idle();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_evict();
    for (int i = 0; i < N; i++) begin
      miss_then(20'h00100 + 20'(i), "R6");
      answer(1'b1, 20'h00200 + 20'(i), 3'b001, 1'b0, 1'b0, "R6");
      go_idle();
    end
    for (int i = 0; i < N; i++) begin
      hit_ok(20'h00100 + 20'(i), 12'h00C, 2'b00, 20'h00200 + 20'(i), "R6 all held");
    end
    miss_then(20'h00300, "R7");
    answer(1'b1, 20'h00400, 3'b001, 1'b0, 1'b0, "R7");
    go_idle();
    hit_ok(20'h00101, 12'h0, 2'b00, 20'h00201, "R7 slot1 kept");
    hit_ok(20'h00300, 12'h0, 2'b00, 20'h00400, "R7 new page");
    miss_then(20'h00100, "R7 slot0 evicted");
    answer(1'b1, 20'h00500, 3'b001, 1'b0, 1'b0, "R7");
    go_idle();
    hit_ok(20'h00102, 12'h0, 2'b00, 20'h00202, "R7 slot2 kept");
    miss_then(20'h00101, "R7 pointer advanced");
    answer(1'b0, 20'h0, 3'b0, 1'b0, 1'b0, "R7");
    go_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_va = '0; req_acc = 2'b00;
    walk_done = 1'b0; walk_ok = 1'b0; walk_ppn = '0; walk_perm = '0; walk_dirty = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_fill_and_hit();
    t_dirty_hit();
    t_prot();
    t_walk_store();
    t_page_fault();
    t_flush();
    t_evict();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule